// File: doc/BRIEF.md
# Four-Channel Round-Robin Sequencer

This block decides which input channel of a multi-input converter front end is converted next. In manual mode the channel comes straight from a 2-bit address input. The channel is captured when a conversion starts, which is the falling edge of the active-low busy input. In continuous mode the block picks the channel itself and advances by one channel for each conversion, wrapping after the highest channel. It also drives the channel it will use next onto its address output, and raises an enable so that the shared address pins can change direction.

Continuous mode resumes at the channel after the last address captured in manual mode. A power-down pulse that lasts long enough zeroes the sequence pointer when it is released, so the next continuous conversion uses channel 0. A shorter pulse is ignored. The block also reports when the converter may run back to back: only while continuous mode is on and chip-select, read/convert and power-down are all low. The analog multiplexer and the conversion itself sit outside this block. All inputs are synchronous to `clk`.

Top module: `chan_seq`

## Requirements
- R1: While reset is asserted, `chan` is 0, `addr_out` is 0, `addr_oe` is 0 and `auto_run` is 0.
- R2: In manual mode (`cont_en` low) with `busy_n` high, `chan` takes the value on `addr_in` one clock after it is sampled.
- R3: The first clock that samples `busy_n` low after it was high starts a conversion. In manual mode that clock captures `addr_in` into `chan`. While `busy_n` stays low, `chan` holds, and changes on `addr_in` are ignored.
- R4: When continuous mode is entered, `addr_out` shows the channel after the last one captured in manual mode, modulo 4, and that channel is the one the first continuous conversion uses.
- R5: In continuous mode each conversion start loads `chan` with the value shown on `addr_out` just before it. The pointer then advances by one and wraps from 3 to 0.
- R6: In continuous mode `addr_out` is updated at the conversion start and then holds. When `busy_n` rises it therefore shows the channel for the next conversion.
- R7: `addr_oe` equals `cont_en` delayed by one clock. A bench that stops driving `addr_in` in the same cycle it raises `cont_en`, and drives again only after `addr_oe` has fallen, never overlaps with `addr_oe`.
- R8: After `pwr_dn` has been sampled high on at least PD_MIN_CYC consecutive clocks (40 by default), the clock that first samples it low zeroes the pointer. `addr_out` then reads 0, and the next continuous conversion uses channel 0.
- R9: A `pwr_dn` pulse sampled high on fewer than PD_MIN_CYC clocks leaves the pointer unchanged.
- R10: When a qualifying power-down release and a continuous-mode conversion start fall on the same clock, the conversion uses channel 0 and `addr_out` becomes 1.
- R11: `auto_run` is high exactly when continuous mode is active and `sel_n`, `rdconv` and `pwr_dn` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cont_en | input | 1 | High selects continuous (round-robin) mode |
| sel_n | input | 1 | Chip select, active low |
| rdconv | input | 1 | Read/convert; low requests conversion |
| pwr_dn | input | 1 | Power-down request, active high |
| busy_n | input | 1 | Low while a conversion is in progress |
| addr_in | input | 2 | Channel address from the address pins (manual mode) |
| addr_out | output | 2 | Channel to be converted next (continuous mode) |
| addr_oe | output | 1 | Drive enable for the address pins |
| chan | output | 2 | Channel selected for the current conversion |
| auto_run | output | 1 | Back-to-back conversion permitted |

## Verification
A power-down release can land in the same clock as a conversion start, and then both the pointer clear and the pointer advance want the pointer register. The bench provokes this by dropping `pwr_dn` and `busy_n` in the same cycle. It does so once after a qualifying pulse, where it expects channel 0 and a next address of 1. It does so again after a pulse one cycle too short, where it expects the sequence to carry on undisturbed. The expected channels in every sweep are computed as (start + k) mod 4.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
   typedef enum logic {
      MODE_MANUAL = 1'b0,
      MODE_AUTO   = 1'b1
   } seq_mode_e;
endpackage

// File: rtl/busy_edge_det.sv
module busy_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_n,
   output logic conv_start
);
   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b1;
      else        busy_q <= busy_n;
   end

   // conversion begins on the first sample of busy low
   assign conv_start = busy_q & ~busy_n;
endmodule

// File: rtl/pd_release.sv
module pd_release #(
   parameter int PD_MIN_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_dn,
   output logic ptr_clear
);
   logic pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pd_q <= 1'b0;
      else        pd_q <= pwr_dn;
   end

   generate
      if (PD_MIN_CYC == 0) begin : g_any_pulse
         assign ptr_clear = pd_q & ~pwr_dn;
      end else begin : g_width_count
         localparam int CW = $clog2(PD_MIN_CYC + 1);
         localparam logic [CW-1:0] LIM = CW'(PD_MIN_CYC);
         logic [CW-1:0] hi_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           hi_cnt <= '0;
            else if (!pwr_dn)     hi_cnt <= '0;
            else if (hi_cnt != LIM) hi_cnt <= hi_cnt + 1'b1;
         end

         assign ptr_clear = pd_q & ~pwr_dn & (hi_cnt == LIM);
      end
   endgenerate
endmodule

// File: rtl/chan_ptr.sv
module chan_ptr
   import chan_seq_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int AW     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  seq_mode_e     mode,
   input  logic          conv_start,
   input  logic          idle,
   input  logic          ptr_clear,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] chan,
   output logic [AW-1:0] next_ch
);
   logic [AW-1:0] src;
   logic [AW-1:0] inc_src;
   logic [AW-1:0] inc_addr;

   // a qualifying power-down release overrides the stored pointer
   assign src = ptr_clear ? '0 : next_ch;

   generate
      if ((1 << AW) == NUM_CH) begin : g_pow2_wrap
         assign inc_src  = src + 1'b1;
         assign inc_addr = addr_in + 1'b1;
      end else begin : g_cmp_wrap
         localparam logic [AW-1:0] TOP = AW'(NUM_CH - 1);
         assign inc_src  = (src >= TOP)     ? '0 : src + 1'b1;
         assign inc_addr = (addr_in >= TOP) ? '0 : addr_in + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan    <= '0;
         next_ch <= '0;
      end else if (conv_start) begin
         if (mode == MODE_AUTO) begin
            chan    <= src;
            next_ch <= inc_src;
         end else begin
            chan    <= addr_in;
            next_ch <= inc_addr;
         end
      end else begin
         if (ptr_clear) next_ch <= '0;
         if (mode == MODE_MANUAL && idle) chan <= addr_in;
      end
   end
endmodule

// File: rtl/chan_seq.sv
module chan_seq
   import chan_seq_pkg::*;
#(
   parameter  int NUM_CH     = 4,
   parameter  int PD_MIN_CYC = 40,
   localparam int AW         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cont_en,
   input  logic          sel_n,
   input  logic          rdconv,
   input  logic          pwr_dn,
   input  logic          busy_n,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out,
   output logic          addr_oe,
   output logic [AW-1:0] chan,
   output logic          auto_run
);
   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("chan_seq: NUM_CH must be at least 2");
      end
      if (PD_MIN_CYC < 0) begin : g_bad_pd
         $error("chan_seq: PD_MIN_CYC must not be negative");
      end
   endgenerate

   seq_mode_e     mode_q;
   logic          conv_start;
   logic          ptr_clear;
   logic [AW-1:0] next_ch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_MANUAL;
      else        mode_q <= cont_en ? MODE_AUTO : MODE_MANUAL;
   end

   busy_edge_det i_busy_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_n     (busy_n),
      .conv_start (conv_start)
   );

   pd_release #(.PD_MIN_CYC(PD_MIN_CYC)) i_pd_release (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_dn    (pwr_dn),
      .ptr_clear (ptr_clear)
   );

   chan_ptr #(.NUM_CH(NUM_CH), .AW(AW)) i_chan_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_q),
      .conv_start (conv_start),
      .idle       (busy_n),
      .ptr_clear  (ptr_clear),
      .addr_in    (addr_in),
      .chan       (chan),
      .next_ch    (next_ch)
   );

   assign addr_oe  = (mode_q == MODE_AUTO);
   assign addr_out = next_ch;
   assign auto_run = (mode_q == MODE_AUTO) & ~sel_n & ~rdconv & ~pwr_dn;
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk #(
   parameter int AW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cont_en,
   input logic          pwr_dn,
   input logic          busy_n,
   input logic [AW-1:0] addr_out,
   input logic          addr_oe,
   input logic [AW-1:0] chan,
   input logic          auto_run
);
   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R7: drive enable follows the mode request one clock later
   a_r7_oe_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0) |-> (addr_oe == $past(cont_en)));

   // R3: channel frozen while a conversion is in progress
   a_r3_hold_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !$past(busy_n) && !$past(busy_n, 2)) |-> $stable(chan));

   // R5: a continuous-mode start takes the announced address
   a_r5_auto_step: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(busy_n, 2) && !$past(busy_n) && $past(addr_oe)
       && !($past(pwr_dn, 2) && !$past(pwr_dn)))
      |-> (chan == $past(addr_out)));

   // R6: announced address holds through a conversion
   a_r6_next_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !$past(busy_n) && !$past(busy_n, 2) && addr_oe
       && !$past(pwr_dn, 2)) |-> $stable(addr_out));

   // R11: back-to-back running only in continuous mode and out of power-down
   a_r11_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
      auto_run |-> (addr_oe && !pwr_dn));
endmodule

bind chan_seq chan_seq_chk #(.AW(AW)) i_chan_seq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cont_en  (cont_en),
   .pwr_dn   (pwr_dn),
   .busy_n   (busy_n),
   .addr_out (addr_out),
   .addr_oe  (addr_oe),
   .chan     (chan),
   .auto_run (auto_run)
);

// File: tb/test_chan_seq.sv
`timescale 1ns/1ps
module test_chan_seq;
   localparam int NCH = 4;
   localparam int PDM = 40;

   logic       clk = 1'b0;
   logic       rst_n, cont_en, sel_n, rdconv, pwr_dn, busy_n;
   logic       tb_drv;
   logic [1:0] tb_addr;
   logic [1:0] addr_in, addr_out, chan;
   logic       addr_oe, auto_run;

   int checks = 0;
   int fails  = 0;
   int contention = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   assign addr_in = tb_drv ? tb_addr : 2'b00;

   chan_seq #(.NUM_CH(NCH), .PD_MIN_CYC(PDM)) i_chan_seq (
      .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .sel_n(sel_n),
      .rdconv(rdconv), .pwr_dn(pwr_dn), .busy_n(busy_n),
      .addr_in(addr_in), .addr_out(addr_out), .addr_oe(addr_oe),
      .chan(chan), .auto_run(auto_run)
   );

   always @(negedge clk) if (rst_n && addr_oe && tb_drv) contention++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_conv(input int expch, input string req, input logic [1:0] mid);
      busy_n = 1'b0;
      step(1);
      chk(req, int'(chan), expch);
      tb_addr = mid;
      step(3);
      chk("R3 hold", int'(chan), expch);
      busy_n = 1'b1;
      step(2);
   endtask

   task automatic pd_pulse(input int n);
      pwr_dn = 1'b1;
      step(n);
      pwr_dn = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cont_en = 0; sel_n = 1; rdconv = 1; pwr_dn = 0; busy_n = 1;
      tb_drv = 1; tb_addr = 2'd3;
      step(3);
      chk("R1 chan",     int'(chan), 0);
      chk("R1 addr_out", int'(addr_out), 0);
      chk("R1 addr_oe",  int'(addr_oe), 0);
      chk("R1 auto_run", int'(auto_run), 0);
      rst_n = 1;
      step(1);

      // R2 direct selection while idle
      for (int v = 0; v < NCH; v++) begin
         tb_addr = 2'(v);
         step(1);
         chk("R2 direct", int'(chan), v);
      end

      // sweep every start address through manual load and a continuous run
      for (int a = 0; a < NCH; a++) begin
         tb_addr = 2'(a);
         step(1);
         do_conv(a, "R3 latch", 2'((a + 2) % NCH));
         tb_drv = 0; cont_en = 1;
         step(1);
         chk("R7 oe on", int'(addr_oe), 1);
         chk("R4 resume", int'(addr_out), (a + 1) % NCH);
         for (int k = 0; k < 6; k++) begin
            do_conv((a + 1 + k) % NCH, "R5 step", 2'b00);
            chk("R6 next", int'(addr_out), (a + 2 + k) % NCH);
         end
         cont_en = 0;
         step(1);
         chk("R7 oe off", int'(addr_oe), 0);
         tb_drv = 1; tb_addr = 2'(a);
         step(1);
      end

      // R9 short pulse in manual mode
      tb_addr = 2'd2;
      step(1);
      do_conv(2, "R3 latch", 2'd2);
      pd_pulse(PDM - 1);
      step(2);
      tb_drv = 0; cont_en = 1;
      step(1);
      chk("R9 short pulse", int'(addr_out), 3);
      do_conv(3, "R9 short pulse", 2'b00);

      // R8 qualifying pulse in continuous mode
      pd_pulse(PDM);
      step(1);
      chk("R8 cleared", int'(addr_out), 0);
      do_conv(0, "R8 first ch0", 2'b00);
      chk("R8 next", int'(addr_out), 1);
      do_conv(1, "R5 step", 2'b00);

      // R10 release coincides with conversion start
      pwr_dn = 1'b1;
      step(PDM);
      pwr_dn = 1'b0; busy_n = 1'b0;
      step(1);
      chk("R10 chan", int'(chan), 0);
      chk("R10 next", int'(addr_out), 1);
      step(3);
      busy_n = 1'b1;
      step(2);

      // short pulse coinciding with start: sequence undisturbed
      pwr_dn = 1'b1;
      step(PDM - 1);
      pwr_dn = 1'b0; busy_n = 1'b0;
      step(1);
      chk("R9 coincident chan", int'(chan), 1);
      chk("R9 coincident next", int'(addr_out), 2);
      step(3);
      busy_n = 1'b1;
      step(2);

      // R11 gating sweep in continuous mode
      for (int s = 0; s < 8; s++) begin
         sel_n = s[0]; rdconv = s[1]; pwr_dn = s[2];
         #1;
         chk("R11 gate", int'(auto_run), (s == 0) ? 1 : 0);
         pwr_dn = 1'b0;
         step(1);
      end
      sel_n = 1; rdconv = 1;

      // R8 from manual mode: clear overrides the last loaded address
      cont_en = 0;
      step(1);
      tb_drv = 1; tb_addr = 2'd2;
      step(1);
      do_conv(2, "R3 latch", 2'd2);
      pd_pulse(PDM);
      step(1);
      tb_drv = 0; cont_en = 1;
      step(1);
      chk("R8 manual clear", int'(addr_out), 0);
      do_conv(0, "R8 first ch0", 2'b00);

      // R11 off in manual mode
      cont_en = 0;
      step(1);
      sel_n = 0; rdconv = 0;
      #1;
      chk("R11 manual", int'(auto_run), 0);
      sel_n = 1; rdconv = 1;
      tb_drv = 1;
      step(2);

      chk("R7 contention", contention, 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule